// File: doc/BRIEF.md
# Power Domain On/Off Sequencer

This block brings a single peripheral power domain up or down when it receives an on or off command. It drives the domain's reset-clock enable. It exchanges self-clearing power-up and power-down requests with a power gating controller, and it updates the power-control bits that belong to the domain. It also runs an active-low power-down handshake with the bus bridge in front of the domain. The steps always run in a fixed order. A settle delay separates gating completion from the release of the bridge. Every wait on an external party is bounded by a timeout.

Static configuration inputs describe the domain. They state whether it has reset clocks, whether those clocks stay running after power-on, whether it has a gating-controller request, whether it has a bridge handshake, and which power-control bits it owns. The configuration is captured when a command is accepted. On success the block gives a one-cycle done pulse. On a timeout it aborts and raises a sticky error.

Top module: `pd_sequencer`

## Requirements
- R1: After a synchronous reset, clk_en, pup_req, pdn_req, brg_pdn_req_n, busy, done and error are all 0, and every bit of pwr_ctrl is 1 (1 means gated).
- R2: An accepted on command enables clk_en in the next cycle when cfg_has_clk is 1. It raises pup_req when cfg_has_pgc is 1 and holds it until pgc_done is seen. In that same cycle it clears the pwr_ctrl bits selected by cfg_ctrl_mask.
- R3: After the gating stage, the sequencer waits SETTLE_US microseconds of clock cycles before it drives brg_pdn_req_n high. With no gating stage, brg_pdn_req_n first reads high SETTLE_CYC+1 cycles after the command cycle.
- R4: At the end of power-on, clk_en goes low unless cfg_keep_clk is 1.
- R5: An accepted off command enables clk_en when cfg_has_clk is 1 and cfg_keep_clk is 0. It drives brg_pdn_req_n low and waits for brg_pdn_ack_n to read low.
- R6: After the off handshake, the sequencer sets the selected pwr_ctrl bits and raises pdn_req until pgc_done. clk_en is then low at the end, even when cfg_keep_clk is 1.
- R7: If a request is not completed, or the acknowledge does not come, within TIMEOUT_US microseconds of cycles, the sequencer aborts. It sets error, drops pup_req and pdn_req, and turns off clk_en only if the sequence itself enabled it. For a stalled power-up, error first reads 1 exactly TMO_CYC+1 cycles after the command cycle.
- R8: With cfg_has_pgc at 0, pup_req and pdn_req stay low and pwr_ctrl is left unchanged.
- R9: With cfg_has_hsk at 0, brg_pdn_req_n keeps its value in both directions.
- R10: cfg_ctrl_mask bit i selects pwr_ctrl[i]. Any number of bits may be selected, and all selected bits change together.
- R11: busy is high while a sequence runs, and on and off commands that arrive then are ignored. If cmd_on and cmd_off are both high in an idle cycle, the on command wins.
- R12: done is a one-cycle pulse after a successful sequence. error stays high until the next accepted command clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_on | input | 1 | Power-on command |
| cmd_off | input | 1 | Power-off command |
| cfg_has_clk | input | 1 | Domain has reset clocks |
| cfg_keep_clk | input | 1 | Keep clocks enabled after power-on |
| cfg_has_pgc | input | 1 | Domain has a gating-controller request |
| cfg_has_hsk | input | 1 | Domain has a bridge handshake |
| cfg_ctrl_mask | input | NCTRL | Power-control bits owned by the domain |
| pgc_done | input | 1 | Gating controller has cleared the pending request |
| brg_pdn_ack_n | input | 1 | Bridge power-down acknowledge, active low |
| clk_en | output | 1 | Domain reset-clock enable |
| pup_req | output | 1 | Power-up request to the gating controller |
| pdn_req | output | 1 | Power-down request to the gating controller |
| pwr_ctrl | output | NCTRL | Power-control bits, 1 = gated |
| brg_pdn_req_n | output | 1 | Bridge power-down request, active low |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle success pulse |
| error | output | 1 | Timeout abort, held until the next command |

## Verification
The bench builds the sequencer with CLK_HZ set to 8 MHz and keeps the other defaults. That makes the settle delay 40 cycles and the timeout 8000 cycles, so both windows can be counted cycle-exactly within a short run. It also leaves room for timeout aborts in both the gating wait and the handshake wait. With four power-control bits, the bench can use masks of one, two and all bits. It can also check that bits outside the mask keep their value across a sequence of mixed domain types.

// File: rtl/pd_sequencer.sv
module pd_sequencer #(
  parameter int CLK_HZ     = 125_000_000,
  parameter int SETTLE_US  = 5,
  parameter int TIMEOUT_US = 1000,
  parameter int NCTRL      = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_on,
  input  logic             cmd_off,
  input  logic             cfg_has_clk,
  input  logic             cfg_keep_clk,
  input  logic             cfg_has_pgc,
  input  logic             cfg_has_hsk,
  input  logic [NCTRL-1:0] cfg_ctrl_mask,
  input  logic             pgc_done,
  input  logic             brg_pdn_ack_n,
  output logic             clk_en,
  output logic             pup_req,
  output logic             pdn_req,
  output logic [NCTRL-1:0] pwr_ctrl,
  output logic             brg_pdn_req_n,
  output logic             busy,
  output logic             done,
  output logic             error
);

  localparam int CYC_US     = (CLK_HZ / 1_000_000 > 0) ? CLK_HZ / 1_000_000 : 1;
  localparam int SETTLE_CYC = (CYC_US * SETTLE_US > 0) ? CYC_US * SETTLE_US : 1;
  localparam int TMO_CYC    = (CYC_US * TIMEOUT_US > 0) ? CYC_US * TIMEOUT_US : 1;
  localparam int CNT_MAX    = (TMO_CYC > SETTLE_CYC) ? TMO_CYC : SETTLE_CYC;
  localparam int CW         = $clog2(CNT_MAX + 1);
  localparam logic [CW-1:0] SETTLE_LAST = CW'(SETTLE_CYC - 1);
  localparam logic [CW-1:0] TMO_LAST    = CW'(TMO_CYC - 1);

  typedef enum logic [2:0] {S_IDLE, S_PUP, S_SETTLE, S_HSK, S_PDN} state_t;

  state_t           state;
  logic [CW-1:0]    cnt;
  logic             lat_clk, lat_keep, lat_pgc, lat_hsk, seq_clk;
  logic [NCTRL-1:0] lat_mask;
  logic             tmo;

  assign busy = (state != S_IDLE);
  assign tmo  = (cnt == TMO_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= S_IDLE;
      cnt           <= '0;
      clk_en        <= 1'b0;
      pup_req       <= 1'b0;
      pdn_req       <= 1'b0;
      pwr_ctrl      <= '1;
      brg_pdn_req_n <= 1'b0;
      done          <= 1'b0;
      error         <= 1'b0;
      lat_clk       <= 1'b0;
      lat_keep      <= 1'b0;
      lat_pgc       <= 1'b0;
      lat_hsk       <= 1'b0;
      lat_mask      <= '0;
      seq_clk       <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (cmd_on || cmd_off) begin
            lat_clk  <= cfg_has_clk;
            lat_keep <= cfg_keep_clk;
            lat_pgc  <= cfg_has_pgc;
            lat_hsk  <= cfg_has_hsk;
            lat_mask <= cfg_ctrl_mask;
            error    <= 1'b0;
            cnt      <= '0;
          end
          if (cmd_on) begin
            seq_clk <= cfg_has_clk;
            if (cfg_has_clk) clk_en <= 1'b1;
            if (cfg_has_pgc) begin
              pup_req <= 1'b1;
              state   <= S_PUP;
            end else begin
              state   <= S_SETTLE;
            end
          end else if (cmd_off) begin
            seq_clk <= cfg_has_clk && !cfg_keep_clk;
            if (cfg_has_clk && !cfg_keep_clk) clk_en <= 1'b1;
            if (cfg_has_hsk) begin
              brg_pdn_req_n <= 1'b0;
              state         <= S_HSK;
            end else if (cfg_has_pgc) begin
              pwr_ctrl <= pwr_ctrl | cfg_ctrl_mask;
              pdn_req  <= 1'b1;
              state    <= S_PDN;
            end else begin
              if (cfg_has_clk) clk_en <= 1'b0;
              done <= 1'b1;
            end
          end
        end
        S_PUP: begin
          if (pgc_done) begin
            pup_req  <= 1'b0;
            pwr_ctrl <= pwr_ctrl & ~lat_mask;
            cnt      <= '0;
            state    <= S_SETTLE;
          end else if (tmo) begin
            pup_req <= 1'b0;
            if (seq_clk) clk_en <= 1'b0;
            error   <= 1'b1;
            state   <= S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_SETTLE: begin
          if (cnt == SETTLE_LAST) begin
            if (lat_hsk) brg_pdn_req_n <= 1'b1;
            if (lat_clk && !lat_keep) clk_en <= 1'b0;
            done  <= 1'b1;
            state <= S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_HSK: begin
          if (!brg_pdn_ack_n) begin
            cnt <= '0;
            if (lat_pgc) begin
              pwr_ctrl <= pwr_ctrl | lat_mask;
              pdn_req  <= 1'b1;
              state    <= S_PDN;
            end else begin
              if (lat_clk) clk_en <= 1'b0;
              done  <= 1'b1;
              state <= S_IDLE;
            end
          end else if (tmo) begin
            if (seq_clk) clk_en <= 1'b0;
            error <= 1'b1;
            state <= S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_PDN: begin
          if (pgc_done) begin
            pdn_req <= 1'b0;
            if (lat_clk) clk_en <= 1'b0;
            done  <= 1'b1;
            state <= S_IDLE;
          end else if (tmo) begin
            pdn_req <= 1'b0;
            if (seq_clk) clk_en <= 1'b0;
            error   <= 1'b1;
            state   <= S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_ONE_REQ: assert property (@(posedge clk) disable iff (rst)
    !(pup_req && pdn_req)); // R2
  AST_REQ_BUSY: assert property (@(posedge clk) disable iff (rst)
    (pup_req || pdn_req) |-> busy); // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R12
  AST_ERR_IDLE: assert property (@(posedge clk) disable iff (rst)
    error |-> !busy && !pup_req && !pdn_req); // R7
  AST_BUSY_END: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (done || error)); // R12
  AST_PUP_CLK: assert property (@(posedge clk) disable iff (rst)
    ($rose(pup_req) && lat_clk) |-> clk_en); // R2
  AST_PDN_AFTER_HSK: assert property (@(posedge clk) disable iff (rst)
    ($rose(pdn_req) && lat_hsk) |-> !brg_pdn_req_n); // R6
  AST_PDN_GATED: assert property (@(posedge clk) disable iff (rst)
    pdn_req |-> ((pwr_ctrl & lat_mask) == lat_mask)); // R10
  AST_BRG_AFTER_PUP: assert property (@(posedge clk) disable iff (rst)
    ($rose(brg_pdn_req_n) && lat_pgc) |-> ((pwr_ctrl & lat_mask) == '0)); // R3

endmodule

// File: tb/tb_pd_sequencer.sv
module tb_pd_sequencer;
  localparam int NC     = 4;
  localparam int SETTLE = 40;
  localparam int TMO    = 8000;

  logic clk = 1'b0, rst = 1'b1;
  logic cmd_on = 1'b0, cmd_off = 1'b0;
  logic c_clk = 1'b0, c_keep = 1'b0, c_pgc = 1'b0, c_hsk = 1'b0;
  logic [NC-1:0] c_mask = '0;
  logic pgc_done = 1'b0, ack_n = 1'b0;
  logic clk_en, pup_req, pdn_req, req_n, busy, done, error;
  logic [NC-1:0] pwr_ctrl;
  logic resp_pgc = 1'b1, resp_hsk = 1'b1;
  int   pgc_cnt = 0;
  int   checks = 0, fails = 0;
  logic saw_done, saw_clk;

  always #4 clk = ~clk;

  pd_sequencer #(.CLK_HZ(8_000_000), .NCTRL(NC)) dut (
    .clk(clk), .rst(rst), .cmd_on(cmd_on), .cmd_off(cmd_off),
    .cfg_has_clk(c_clk), .cfg_keep_clk(c_keep), .cfg_has_pgc(c_pgc),
    .cfg_has_hsk(c_hsk), .cfg_ctrl_mask(c_mask), .pgc_done(pgc_done),
    .brg_pdn_ack_n(ack_n), .clk_en(clk_en), .pup_req(pup_req),
    .pdn_req(pdn_req), .pwr_ctrl(pwr_ctrl), .brg_pdn_req_n(req_n),
    .busy(busy), .done(done), .error(error));

  always @(negedge clk) begin
    if ((pup_req || pdn_req) && resp_pgc) pgc_cnt <= pgc_cnt + 1;
    else pgc_cnt <= 0;
    pgc_done <= resp_pgc && (pup_req || pdn_req) && (pgc_cnt == 3);
    ack_n    <= resp_hsk ? req_n : 1'b1;
  end

  // {off, clk, keep, pgc, hsk, mask[4], exp clk_en, exp req_n, exp ctrl[4], exp clk seen}
  localparam logic [15:0] VEC [8] = '{
    16'b0_1_0_1_1_0011_0_1_1100_1,
    16'b1_1_0_1_1_0011_0_0_1111_1,
    16'b0_1_1_0_1_0000_1_1_1111_1,
    16'b1_1_1_0_1_0000_0_0_1111_1,
    16'b0_1_0_1_0_1010_0_0_0101_1,
    16'b1_1_0_1_0_1010_0_0_1111_1,
    16'b0_0_0_1_1_1111_0_1_0000_0,
    16'b1_0_0_1_1_1111_0_0_1111_0
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic setcfg(input logic k, input logic kp, input logic p, input logic h, input logic [NC-1:0] m);
    c_clk = k; c_keep = kp; c_pgc = p; c_hsk = h; c_mask = m;
  endtask

  task automatic issue(input logic on, input logic off);
    cmd_on = on; cmd_off = off;
    @(negedge clk);
    cmd_on = 1'b0; cmd_off = 1'b0;
  endtask

  task automatic wait_end();
    saw_done = 1'b0; saw_clk = 1'b0;
    do begin
      if (done) saw_done = 1'b1;
      if (clk_en && busy) saw_clk = 1'b1;
      @(negedge clk);
    end while (busy);
    if (done) saw_done = 1'b1;
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 clk_en", clk_en, 0);
    chk("R1 requests", {pup_req, pdn_req}, 0);
    chk("R1 pwr_ctrl", pwr_ctrl, 4'hF);
    chk("R1 bridge req_n", req_n, 0);
    chk("R1 busy/done/error", {busy, done, error}, 0);

    // Table walk: R2 R4 R5 R6 R8 R9 R10
    for (int i = 0; i < 8; i++) begin
      setcfg(VEC[i][14], VEC[i][13], VEC[i][12], VEC[i][11], VEC[i][10:7]);
      issue(!VEC[i][15], VEC[i][15]);
      wait_end();
      repeat (2) @(negedge clk);
      chk($sformatf("R4_R6 vec%0d clk_en", i), clk_en, VEC[i][6]);
      chk($sformatf("R3_R9 vec%0d req_n", i), req_n, VEC[i][5]);
      chk($sformatf("R10_R8 vec%0d pwr_ctrl", i), pwr_ctrl, VEC[i][4:1]);
      chk($sformatf("R2_R5 vec%0d clk seen", i), saw_clk, VEC[i][0]);
      chk($sformatf("R12 vec%0d done/error", i), {saw_done, error}, 2'b10);
    end

    // R11 off command during a running on sequence is ignored
    setcfg(1, 0, 1, 1, 4'b0001);
    issue(1, 0);
    @(negedge clk);
    chk("R11 busy", busy, 1);
    cmd_off = 1'b1; @(negedge clk); cmd_off = 1'b0;
    wait_end();
    repeat (10) @(negedge clk);
    chk("R11 ignored off", {busy, req_n, pwr_ctrl}, {1'b0, 1'b1, 4'b1110});

    // R11 simultaneous commands: on wins
    issue(1, 1);
    wait_end();
    repeat (2) @(negedge clk);
    chk("R11 on priority", {req_n, pwr_ctrl}, {1'b1, 4'b1110});
    setcfg(1, 0, 1, 1, 4'b0001);
    issue(0, 1);
    wait_end();
    repeat (2) @(negedge clk);
    chk("R6 restore", {req_n, pwr_ctrl}, {1'b0, 4'b1111});

    // R3 settle delay exact count (no gating stage)
    begin
      int n;
      setcfg(0, 0, 0, 1, 4'b0000);
      cmd_on = 1'b1; @(negedge clk); cmd_on = 1'b0;
      n = 1;
      while (!req_n && n < 1000) begin @(negedge clk); n++; end
      chk("R3 settle cycles", n, SETTLE + 1);
    end
    wait_end();
    issue(0, 1);
    wait_end();
    repeat (3) @(negedge clk);

    // R7 power-up timeout
    resp_pgc = 1'b0;
    setcfg(1, 0, 1, 0, 4'b0001);
    begin
      int n;
      cmd_on = 1'b1; @(negedge clk); cmd_on = 1'b0;
      n = 1; saw_done = 1'b0;
      while (!error && n < TMO + 100) begin
        if (done) saw_done = 1'b1;
        @(negedge clk); n++;
      end
      chk("R7 timeout cycles", n, TMO + 1);
    end
    chk("R7 abort outputs", {busy, pup_req, clk_en, saw_done}, 4'b0000);
    chk("R7 ctrl untouched", pwr_ctrl, 4'b1111);
    repeat (5) @(negedge clk);
    chk("R12 error held", error, 1);

    // R12 error cleared by next command
    resp_pgc = 1'b1;
    issue(1, 0);
    chk("R12 error cleared", error, 0);
    wait_end();
    repeat (2) @(negedge clk);
    chk("R2 recovered on", pwr_ctrl, 4'b1110);

    // R7 handshake timeout during off: enabled clocks turned off
    resp_hsk = 1'b0;
    repeat (2) @(negedge clk);
    setcfg(1, 0, 1, 1, 4'b0001);
    issue(0, 1);
    chk("R5 clk enabled for off", {clk_en, req_n}, 2'b10);
    wait_end();
    chk("R7 hsk abort", {error, clk_en, pdn_req, pwr_ctrl}, {1'b1, 1'b0, 1'b0, 4'b1110});

    finish_run();
  end
endmodule